// File: doc/BRIEF.md
# Bouncing Decimal Digit Display Counter

This block drives one seven-segment digit with a value that climbs from 0 to 9 and then falls back to 0, turning around at both ends without holding either end value for an extra step. One full round trip takes 18 steps. A free-running divider on the fast system clock sets the step rate. On each step the block registers the new value and flips the decimal point. The current value is converted to active-low segment levels.

The four anode lines are copied straight from four button inputs, so the same digit appears on whichever positions the buttons select. The block does no multiplexing between different digits and no debouncing. It has no data stream, so every pin is a plain level with no handshake. A synchronous reset restarts the divider, the value and the decimal point.

Top module: `bounce_digit_display`

## Requirements
- R1: While reset is high at a clock edge, the next state is digit 0 with direction up, decimal point off (seg_o[7]=1) and divider cleared, so seg_o reads 8'b1100_0000.
- R2: From 0 the displayed value rises by one on each step up to 9.
- R3: 9 is shown for exactly one step and is followed by 8, then 7, and so on down to 0.
- R4: After 0 on the way down the next value is 1, so no value is shown on two consecutive steps and the value sequence repeats every 18 steps.
- R5: seg_o[6:0] is the inverse of the lit pattern, with pattern bits ordered g,f,e,d,c,b,a from bit 6 to bit 0 and 1 meaning lit. The patterns are 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R6: seg_o[7] is the active-low decimal point and changes level on every step.
- R7: A step is a one-cycle enable raised when the divider's top bit rises. The first step follows 2^(DIV_W-1) cycles after reset, and later steps come every 2^DIV_W cycles.
- R8: an_o equals btn_i at all times, with no register in the path.
- R9: A reset in the middle of a run restarts the sequence from 0 with the same first-step timing as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (100 MHz on the target) |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 4 | Digit-enable buttons |
| seg_o | output | 8 | Active-low segments: [6:0] g..a, [7] decimal point |
| an_o | output | 4 | Anode lines, copied from btn_i |

## Verification
The assertions check the following on every cycle:
- the step pulse never lasts two cycles;
- the phase stays inside its 18-value range and wraps from the last phase to the first;
- state holds between steps;
- the decimal-point register flips on each step;
- the digit never exceeds 9.

Only the bench's scenarios show the rest. These are the actual order of values across both turnarounds, the exact segment levels for each digit, the cycle distance between steps, the anode pass-through under different button patterns, and the restart after a reset in the middle of a run.

// File: rtl/bounce_pkg.sv
package bounce_pkg;
  localparam int PEAK   = 9;
  localparam int PHASES = 2 * PEAK;
  localparam int PH_W   = $clog2(PHASES);
  localparam int DIG_W  = $clog2(PEAK + 1);

  typedef logic [6:0]       seg_pat_t;
  typedef logic [DIG_W-1:0] digit_t;

  // Lit pattern, bit 6 = g ... bit 0 = a, 1 = lit
  function automatic seg_pat_t digit_pattern(input digit_t d);
    case (d)
      4'd0:    return 7'b0111111;
      4'd1:    return 7'b0000110;
      4'd2:    return 7'b1011011;
      4'd3:    return 7'b1001111;
      4'd4:    return 7'b1100110;
      4'd5:    return 7'b1101101;
      4'd6:    return 7'b1111101;
      4'd7:    return 7'b0000111;
      4'd8:    return 7'b1111111;
      4'd9:    return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction
endpackage

// File: rtl/step_prescaler.sv
module step_prescaler #(
  parameter int DIV_W = 25
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic step_o
);
  logic [DIV_W-1:0] div_q;
  logic             top_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q <= '0;
      top_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      top_q <= div_q[DIV_W-1];
    end
  end

  assign step_o = div_q[DIV_W-1] & ~top_q;

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    step_o |=> !step_o); // R7
endmodule

// File: rtl/bounce_phase.sv
module bounce_phase
  import bounce_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   step_i,
  output digit_t digit_o,
  output logic   dot_on_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] PEAK_PH = PH_W'(PEAK);
  localparam logic [PH_W-1:0] SPAN    = PH_W'(PHASES);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mirrored;
  logic            dot_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      dot_q   <= 1'b0;
    end else if (step_i) begin
      phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
      dot_q   <= ~dot_q;
    end
  end

  // phases 0..9 rise, phases 10..17 fall as 18 - phase
  assign mirrored = SPAN - phase_q;
  assign digit_o  = (phase_q <= PEAK_PH) ? phase_q[DIG_W-1:0] : mirrored[DIG_W-1:0];
  assign dot_on_o = dot_q;

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    phase_q <= LAST_PH); // R4
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && phase_q == LAST_PH) |=> phase_q == '0); // R4
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(phase_q)); // R2
  AST_DOT_FLIP: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i |=> dot_q != $past(dot_q)); // R6
  AST_DIGIT_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
    digit_o <= DIG_W'(PEAK)); // R3
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import bounce_pkg::*;
(
  input  digit_t     digit_i,
  input  logic       dot_on_i,
  output logic [7:0] seg_o
);
  seg_pat_t lit;

  always_comb begin
    lit   = digit_pattern(digit_i);
    seg_o = {~dot_on_i, ~lit};
  end

  always_comb begin
    AST_SEG_NONBLANK: assert (lit != '0); // R5
  end
endmodule

// File: rtl/bounce_digit_display.sv
module bounce_digit_display
  import bounce_pkg::*;
#(
  parameter int DIV_W = 25
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [3:0] btn_i,
  output logic [7:0] seg_o,
  output logic [3:0] an_o
);
  logic   step;
  digit_t digit;
  logic   dot_on;

  step_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_o (step)
  );

  bounce_phase u_phase (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .step_i   (step),
    .digit_o  (digit),
    .dot_on_o (dot_on)
  );

  seg_encoder u_enc (
    .digit_i  (digit),
    .dot_on_i (dot_on),
    .seg_o    (seg_o)
  );

  assign an_o = btn_i;

  AST_SEG_CHANGE_ON_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    step |=> seg_o[7] != $past(seg_o[7])); // R6
endmodule

// File: tb/tb_bounce_digit_display.sv
module tb_bounce_digit_display;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 4;
  localparam int FIRST_GAP  = (1 << (DIV_W - 1)) + 1;
  localparam int STEP_GAP   = 1 << DIV_W;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] btn = 4'h0;
  logic [7:0] seg;
  logic [3:0] an;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  bounce_digit_display #(.DIV_W(DIV_W)) dut (
    .clk_i (clk),
    .rst_i (rst),
    .btn_i (btn),
    .seg_o (seg),
    .an_o  (an)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] lit_of(input int v);
    case (v)
      0: return 7'b0111111; 1: return 7'b0000110; 2: return 7'b1011011;
      3: return 7'b1001111; 4: return 7'b1100110; 5: return 7'b1101101;
      6: return 7'b1111101; 7: return 7'b0000111; 8: return 7'b1111111;
      default: return 7'b1101111;
    endcase
  endfunction

  function automatic int value_at(input int k);
    int p = k % 18;
    return (p <= 9) ? p : 18 - p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Waits at negedges until seg changes, returns cycle distance (0 = timeout)
  task automatic wait_change(output int gap);
    logic [7:0] prev = seg;
    gap = 0;
    for (int i = 1; i <= 4 * STEP_GAP; i++) begin
      @(negedge clk);
      if (seg != prev) begin gap = i; return; end
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check(seg == 8'b1100_0000, "R1", seg, 8'b1100_0000);
    check(seg[7] == 1'b1, "R1 dot off", seg[7], 1'b1);
  endtask

  task automatic t_anodes();
    for (int b = 0; b < 16; b += 5) begin
      @(negedge clk) btn = 4'(b);
      #1 check(an == 4'(b), "R8", an, 4'(b));
    end
    btn = 4'hA;
    #1 check(an == 4'hA, "R8", an, 4'hA);
  endtask

  task automatic t_sequence();
    int gap;
    int prev_val = 0;
    do_reset();
    for (int k = 1; k <= 42; k++) begin
      int v;
      logic [7:0] exp;
      wait_change(gap);
      v   = value_at(k);
      exp = {((k % 2) == 0) ? 1'b1 : 1'b0, ~lit_of(v)};
      if (k == 1) check(gap == FIRST_GAP, "R7 first step", gap, FIRST_GAP);
      else        check(gap == STEP_GAP, "R7 step period", gap, STEP_GAP);
      if (k <= 9)       check(seg == exp, "R2 up ramp", seg, exp);
      else if (k <= 18) check(seg == exp, "R3 down ramp", seg, exp);
      else              check(seg == exp, "R4 repeat cycle", seg, exp);
      check(v != prev_val, "R4 no repeat", v, prev_val);
      check(seg[6:0] == ~lit_of(v), "R5 pattern", seg[6:0], ~lit_of(v));
      check(seg[7] == exp[7], "R6 dot toggle", seg[7], exp[7]);
      prev_val = v;
    end
  endtask

  task automatic t_mid_reset();
    int gap;
    for (int k = 0; k < 5; k++) wait_change(gap);
    do_reset();
    check(seg == 8'b1100_0000, "R9 restart state", seg, 8'b1100_0000);
    wait_change(gap);
    check(gap == FIRST_GAP, "R9 restart timing", gap, FIRST_GAP);
    check(seg == {1'b0, ~lit_of(1)}, "R9 restart value", seg, {1'b0, ~lit_of(1)});
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_anodes();
        t_sequence();
        t_mid_reset();
      end
      begin
        wait (cyc >= WD_LIMIT);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule